// File: doc/BRIEF.md
# Low-Power Mode and Wake Controller

This block sequences the power modes of a small 8-bit microcontroller. It contains a two-bit mode register with an idle bit and a power-down bit. From that register and from its wake and reset inputs it produces three controls:

- a clock enable for the CPU;
- a clock enable for the peripheral domain, which covers interrupt logic, the timer and the serial port;
- a run/stop request for the oscillator.

In idle, only the CPU clock is held off. An enabled pending interrupt clears the idle bit in hardware.

In power-down, both clock enables drop and the oscillator is asked to stop. A low level on any enabled active-low wake pin requests the oscillator again at once, without waiting for a clock. A fixed stabilisation count must then expire. Power-down ends only when, in addition, one of the pins seen low has been released. Clearing the power-down bit is the only register change on that exit.

The block also qualifies an active-low reset pin. Its low time is counted in oscillator cycles against a threshold that depends on the mode. The resulting reset output is stretched to a minimum width and clears both mode bits.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: A register write with `ctrl_wdata_i` = 2'b01 (bit 0 = idle, bit 1 = power-down), made while running, sets `ctrl_q_o` to 2'b01 on the next clock. In that state `cpu_clk_en_o` is 0, while `per_clk_en_o` and `osc_en_o` stay 1.
- R2: In idle, `irq_pend_i` high at a clock edge clears the idle bit at that edge, and `cpu_clk_en_o` returns to 1.
- R3: A write of 2'b10 enters power-down. `ctrl_q_o` becomes 2'b10, both clock enables become 0 and `osc_en_o` becomes 0.
- R4: A write of 2'b11 enters power-down only, so `ctrl_q_o` reads 2'b10.
- R5: In power-down, `osc_en_o` follows a low level on any wake pin whose `wake_en_i` bit is 1, without waiting for a clock edge. A low level on a wake pin whose enable bit is 0 leaves `osc_en_o` at 0 and leaves the block in power-down.
- R6: When several enabled wake pins are low, power-down exit completes once the first of them is released, even if the others stay low. While all of them stay low, the block stays in power-down.
- R7: After a wake pin restarts the oscillator, both clock enables stay 0 for STAB_CYCLES (default 1024) clocks, even if the pin has already been released. When the count ends and a release has been seen, the block returns to running with `ctrl_q_o` = 2'b00.
- R8: When not in idle, `rst_pin_ni` must be low for RST_PIN_CYC (default 64) clocks before `rst_o` asserts. A shorter low pulse leaves `rst_o` at 0.
- R9: In idle, the reset pin is accepted after two machine cycles. That is 24 clocks when `x2_mode_i` = 0 (12-clock machine cycle) and 12 clocks when `x2_mode_i` = 1 (6-clock machine cycle). Shorter pulses leave `rst_o` at 0 and the block stays in idle.
- R10: `rst_o` is 1 after `rst_ni` releases. Once asserted, it stays 1 while the pin is held low and for at least RST_HOLD (default 12) clocks after the last qualifying cycle.
- R11: A qualified reset clears both mode bits and returns the block to running, whether it was in idle or in power-down. In power-down, a low reset pin also requests the oscillator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| x2_mode_i | input | 1 | 1 selects the 6-clock machine cycle |
| ctrl_we_i | input | 1 | Mode register write strobe |
| ctrl_wdata_i | input | 2 | Mode write data: bit 0 idle, bit 1 power-down |
| ctrl_q_o | output | 2 | Current mode bits |
| irq_pend_i | input | 1 | An enabled interrupt is pending |
| wake_n_i | input | N_WAKE | Active-low external wake pins |
| wake_en_i | input | N_WAKE | Per-pin wake enable |
| rst_pin_ni | input | 1 | Active-low reset pin |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator run request |
| rst_o | output | 1 | Stretched system reset, active high |

## Verification
The hardest situation to reach from the ports is the stabilisation window in which a wake pin is released early. The exit must then wait for the count to end rather than follow the pin. A close second is the case where two pins are held low, so that only the first release may complete the exit. The stimulus reaches both cases by driving the wake pins on the falling edge and holding them through waits of known length on each side of the 1024-clock window. The state is sampled at the ports roughly 900 clocks into the window, and again past its end. A further sequence enters idle and sends reset-pin pulses just below and just above the two-machine-cycle limit in both clock modes.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_IDLE  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_STAB  = 2'd3
  } pmc_state_e;

  localparam int unsigned CTRL_IDLE_BIT = 0;
  localparam int unsigned CTRL_PD_BIT   = 1;
endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // pins idle high, so reset to 1
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '1;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pmc_rst_qual.sv
module pmc_rst_qual #(
  parameter int unsigned RST_PIN_CYC = 64,
  parameter int unsigned RST_HOLD    = 12,
  parameter int unsigned MC_X1       = 12,
  parameter int unsigned MC_X2       = 6,
  parameter int unsigned IDLE_MC     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_pin_ni,
  input  logic idle_i,
  input  logic x2_i,
  output logic rst_o
);
  localparam int unsigned CW      = $clog2(RST_PIN_CYC + 1);
  localparam int unsigned HW      = $clog2(RST_HOLD + 1);
  localparam int unsigned IDLE_X1 = IDLE_MC * MC_X1;
  localparam int unsigned IDLE_X2 = IDLE_MC * MC_X2;

  logic          pin_s;
  logic          pin_low;
  logic [CW-1:0] low_cnt_q;
  logic [CW-1:0] thr;
  logic          hit;
  logic [HW-1:0] hold_q;

  pmc_sync #(.W(1), .STAGES(SYNC_STAGES)) i_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rst_pin_ni),
    .q_o   (pin_s)
  );

  assign pin_low = ~pin_s;

  // oscillator-live threshold; idle only needs two machine cycles
  always_comb begin
    if (idle_i) thr = x2_i ? CW'(IDLE_X2) : CW'(IDLE_X1);
    else        thr = CW'(RST_PIN_CYC);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            low_cnt_q <= '0;
    else if (!pin_low)                      low_cnt_q <= '0;
    else if (low_cnt_q < CW'(RST_PIN_CYC))  low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign hit = pin_low && (low_cnt_q >= thr);

  // reload while held so a mode change under reset cannot cut it short
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       hold_q <= HW'(RST_HOLD);
    else if (hit || (rst_o && pin_low)) hold_q <= HW'(RST_HOLD);
    else if (hold_q != '0)             hold_q <= hold_q - 1'b1;
  end

  assign rst_o = (hold_q != '0);
endmodule

// File: rtl/pmc_wake.sv
module pmc_wake #(
  parameter int unsigned N_WAKE      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_WAKE-1:0] wake_n_i,
  input  logic [N_WAKE-1:0] wake_en_i,
  input  logic              arm_i,
  output logic              req_o,
  output logic              low_o,
  output logic              rel_o
);
  logic [N_WAKE-1:0] wake_s;
  logic [N_WAKE-1:0] raw_low;
  logic [N_WAKE-1:0] s_low;
  logic [N_WAKE-1:0] armed_q;
  logic [N_WAKE-1:0] s_rel;
  logic              rel_q;

  pmc_sync #(.W(N_WAKE), .STAGES(SYNC_STAGES)) i_wake_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wake_n_i),
    .q_o   (wake_s)
  );

  for (genvar i = 0; i < N_WAKE; i++) begin : g_pin
    assign raw_low[i] = wake_en_i[i] & ~wake_n_i[i];
    assign s_low[i]   = wake_en_i[i] & ~wake_s[i];
    assign s_rel[i]   = armed_q[i] & wake_s[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     armed_q[i] <= 1'b0;
      else if (!arm_i) armed_q[i] <= 1'b0;
      else if (s_low[i]) armed_q[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rel_q <= 1'b0;
    else if (!arm_i)  rel_q <= 1'b0;
    else if (|s_rel)  rel_q <= 1'b1;
  end

  // raw path: must work while the clock is stopped
  assign req_o = |raw_low;
  assign low_o = |s_low;
  assign rel_o = rel_q;
endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
  import pmc_pkg::*;
#(
  parameter int unsigned STAB_CYCLES = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sys_rst_i,
  input  logic       ctrl_we_i,
  input  logic [1:0] ctrl_wdata_i,
  input  logic       irq_pend_i,
  input  logic       wake_req_i,
  input  logic       wake_low_i,
  input  logic       wake_rel_i,
  input  logic       rst_pin_low_i,
  output logic [1:0] ctrl_q_o,
  output logic       idle_o,
  output logic       arm_o,
  output logic       cpu_clk_en_o,
  output logic       per_clk_en_o,
  output logic       osc_en_o
);
  localparam int unsigned SW = $clog2(STAB_CYCLES + 1);

  pmc_state_e    state_q, state_d;
  logic [SW-1:0] stab_cnt_q;
  logic          stab_done;

  assign stab_done = (stab_cnt_q == SW'(STAB_CYCLES));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (ctrl_we_i) begin
          if (ctrl_wdata_i[CTRL_PD_BIT])        state_d = ST_SLEEP;
          else if (ctrl_wdata_i[CTRL_IDLE_BIT]) state_d = ST_IDLE;
        end
      end
      ST_IDLE:  if (irq_pend_i)               state_d = ST_RUN;
      ST_SLEEP: if (wake_low_i)               state_d = ST_STAB;
      ST_STAB:  if (stab_done && wake_rel_i)  state_d = ST_RUN;
      default:                                state_d = ST_RUN;
    endcase
    if (sys_rst_i) state_d = ST_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            stab_cnt_q <= '0;
    else if (state_q != ST_STAB)            stab_cnt_q <= '0;
    else if (!stab_done)                    stab_cnt_q <= stab_cnt_q + 1'b1;
  end

  assign ctrl_q_o[CTRL_IDLE_BIT] = (state_q == ST_IDLE);
  assign ctrl_q_o[CTRL_PD_BIT]   = (state_q == ST_SLEEP) || (state_q == ST_STAB);
  assign idle_o       = (state_q == ST_IDLE);
  assign arm_o        = ctrl_q_o[CTRL_PD_BIT];
  assign cpu_clk_en_o = (state_q == ST_RUN);
  assign per_clk_en_o = (state_q == ST_RUN) || (state_q == ST_IDLE);
  assign osc_en_o     = (state_q != ST_SLEEP) || wake_req_i || rst_pin_low_i;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int unsigned N_WAKE      = 2,
  parameter int unsigned STAB_CYCLES = 1024,
  parameter int unsigned RST_PIN_CYC = 64,
  parameter int unsigned RST_HOLD    = 12,
  parameter int unsigned MC_X1       = 12,
  parameter int unsigned MC_X2       = 6,
  parameter int unsigned IDLE_MC     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              x2_mode_i,
  input  logic              ctrl_we_i,
  input  logic [1:0]        ctrl_wdata_i,
  output logic [1:0]        ctrl_q_o,
  input  logic              irq_pend_i,
  input  logic [N_WAKE-1:0] wake_n_i,
  input  logic [N_WAKE-1:0] wake_en_i,
  input  logic              rst_pin_ni,
  output logic              cpu_clk_en_o,
  output logic              per_clk_en_o,
  output logic              osc_en_o,
  output logic              rst_o
);
  logic idle;
  logic arm;
  logic wake_req;
  logic wake_low;
  logic wake_rel;

  pmc_rst_qual #(
    .RST_PIN_CYC(RST_PIN_CYC),
    .RST_HOLD   (RST_HOLD),
    .MC_X1      (MC_X1),
    .MC_X2      (MC_X2),
    .IDLE_MC    (IDLE_MC),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_rst_qual (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rst_pin_ni(rst_pin_ni),
    .idle_i    (idle),
    .x2_i      (x2_mode_i),
    .rst_o     (rst_o)
  );

  pmc_wake #(
    .N_WAKE     (N_WAKE),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_wake (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wake_n_i (wake_n_i),
    .wake_en_i(wake_en_i),
    .arm_i    (arm),
    .req_o    (wake_req),
    .low_o    (wake_low),
    .rel_o    (wake_rel)
  );

  pmc_seq #(
    .STAB_CYCLES(STAB_CYCLES)
  ) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sys_rst_i    (rst_o),
    .ctrl_we_i    (ctrl_we_i),
    .ctrl_wdata_i (ctrl_wdata_i),
    .irq_pend_i   (irq_pend_i),
    .wake_req_i   (wake_req),
    .wake_low_i   (wake_low),
    .wake_rel_i   (wake_rel),
    .rst_pin_low_i(~rst_pin_ni),
    .ctrl_q_o     (ctrl_q_o),
    .idle_o       (idle),
    .arm_o        (arm),
    .cpu_clk_en_o (cpu_clk_en_o),
    .per_clk_en_o (per_clk_en_o),
    .osc_en_o     (osc_en_o)
  );
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int unsigned N_WAKE   = 2,
  parameter int unsigned RST_HOLD = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        ctrl_q_o,
  input logic              irq_pend_i,
  input logic [N_WAKE-1:0] wake_n_i,
  input logic [N_WAKE-1:0] wake_en_i,
  input logic              cpu_clk_en_o,
  input logic              per_clk_en_o,
  input logic              osc_en_o,
  input logic              rst_o
);
  logic [15:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                hi_cnt_q <= '0;
    else if (!rst_o)            hi_cnt_q <= '0;
    else if (hi_cnt_q != '1)    hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  a_r1_idle_gates_cpu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q_o[0] |-> (!cpu_clk_en_o && per_clk_en_o && osc_en_o));

  a_r2_irq_ends_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q_o[0] && irq_pend_i) |=> !ctrl_q_o[0]);

  a_r3_pd_gates_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q_o[1] |-> (!cpu_clk_en_o && !per_clk_en_o));

  a_r4_bits_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_q_o[0] && ctrl_q_o[1]));

  a_r5_osc_off_only_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> ctrl_q_o[1]);

  a_r5_low_pin_runs_osc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q_o[1] && |(wake_en_i & ~wake_n_i)) |-> osc_en_o);

  a_r7_exit_after_osc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_q_o[1]) |-> $past(osc_en_o));

  a_r10_min_rst_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_o) |-> (hi_cnt_q >= 16'(RST_HOLD)));
endmodule

bind pwr_mode_ctrl pmc_checker #(
  .N_WAKE  (N_WAKE),
  .RST_HOLD(RST_HOLD)
) i_pmc_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_q_o    (ctrl_q_o),
  .irq_pend_i  (irq_pend_i),
  .wake_n_i    (wake_n_i),
  .wake_en_i   (wake_en_i),
  .cpu_clk_en_o(cpu_clk_en_o),
  .per_clk_en_o(per_clk_en_o),
  .osc_en_o    (osc_en_o),
  .rst_o       (rst_o)
);

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_WAKE     = 2;

  logic              clk = 1'b0;
  logic              rst_ni;
  logic              x2_mode;
  logic              ctrl_we;
  logic [1:0]        ctrl_wdata;
  logic [1:0]        ctrl_q;
  logic              irq_pend;
  logic [N_WAKE-1:0] wake_n;
  logic [N_WAKE-1:0] wake_en;
  logic              rst_pin_n;
  logic              cpu_en;
  logic              per_en;
  logic              osc_en;
  logic              rst_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl i_pwr_mode_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .x2_mode_i   (x2_mode),
    .ctrl_we_i   (ctrl_we),
    .ctrl_wdata_i(ctrl_wdata),
    .ctrl_q_o    (ctrl_q),
    .irq_pend_i  (irq_pend),
    .wake_n_i    (wake_n),
    .wake_en_i   (wake_en),
    .rst_pin_ni  (rst_pin_n),
    .cpu_clk_en_o(cpu_en),
    .per_clk_en_o(per_en),
    .osc_en_o    (osc_en),
    .rst_o       (rst_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ctrl(input logic [1:0] v);
    @(negedge clk);
    ctrl_we    = 1'b1;
    ctrl_wdata = v;
    @(negedge clk);
    ctrl_we    = 1'b0;
  endtask

  task automatic apply_reset(input bit check);
    rst_ni    = 1'b0;
    x2_mode   = 1'b0;
    ctrl_we   = 1'b0;
    ctrl_wdata = 2'b00;
    irq_pend  = 1'b0;
    wake_n    = '1;
    wake_en   = '1;
    rst_pin_n = 1'b1;
    cyc(3);
    rst_ni = 1'b1;
    cyc(5);
    if (check) chk("R10 rst_o after power-on", rst_out, 1'b1);
    cyc(15);
    if (check) begin
      chk("R10 rst_o released", rst_out, 1'b0);
      chk("R11 reset mode bits", ctrl_q, 2'b00);
      chk("R1 reset cpu enable", cpu_en, 1'b1);
      chk("R1 reset per enable", per_en, 1'b1);
      chk("R5 reset osc enable", osc_en, 1'b1);
    end
  endtask

  task automatic t_idle;
    write_ctrl(2'b01);
    chk("R1 idle bit", ctrl_q, 2'b01);
    chk("R1 cpu gated", cpu_en, 1'b0);
    chk("R1 per running", per_en, 1'b1);
    chk("R1 osc running", osc_en, 1'b1);
    cyc(5);
    chk("R1 idle holds", cpu_en, 1'b0);
    irq_pend = 1'b1;
    cyc(1);
    irq_pend = 1'b0;
    chk("R2 idle cleared", ctrl_q, 2'b00);
    chk("R2 cpu restored", cpu_en, 1'b1);
  endtask

  task automatic t_pd_stab;
    wake_en = 2'b11;
    write_ctrl(2'b11);
    chk("R4 pd wins", ctrl_q, 2'b10);
    chk("R3 cpu off", cpu_en, 1'b0);
    chk("R3 per off", per_en, 1'b0);
    chk("R3 osc off", osc_en, 1'b0);
    wake_n[0] = 1'b0;
    #1;
    chk("R5 osc restarts on low pin", osc_en, 1'b1);
    cyc(5);
    wake_n[0] = 1'b1;
    cyc(900);
    chk("R7 still in pd during stab", ctrl_q, 2'b10);
    chk("R7 cpu off during stab", cpu_en, 1'b0);
    chk("R7 osc on during stab", osc_en, 1'b1);
    cyc(200);
    chk("R7 exit after stab", ctrl_q, 2'b00);
    chk("R7 cpu on after exit", cpu_en, 1'b1);
    chk("R7 per on after exit", per_en, 1'b1);
  endtask

  task automatic t_pd_pins;
    wake_en = 2'b01;
    write_ctrl(2'b10);
    chk("R3 pd entered", ctrl_q, 2'b10);
    wake_n[1] = 1'b0;
    cyc(10);
    chk("R5 disabled pin no osc", osc_en, 1'b0);
    chk("R5 disabled pin stays pd", ctrl_q, 2'b10);
    wake_n[1] = 1'b1;
    cyc(3);
    wake_en = 2'b11;
    wake_n  = 2'b00;
    cyc(1100);
    chk("R6 held low stays pd", ctrl_q, 2'b10);
    wake_n[1] = 1'b1;
    cyc(8);
    chk("R6 first release exits", ctrl_q, 2'b00);
    chk("R6 cpu on", cpu_en, 1'b1);
    wake_n[0] = 1'b1;
    cyc(3);
  endtask

  task automatic t_rst_run;
    rst_pin_n = 1'b0;
    cyc(50);
    rst_pin_n = 1'b1;
    cyc(3);
    chk("R8 short pulse ignored", rst_out, 1'b0);
    rst_pin_n = 1'b0;
    cyc(75);
    chk("R8 long pulse resets", rst_out, 1'b1);
    rst_pin_n = 1'b1;
    cyc(8);
    chk("R10 stretched", rst_out, 1'b1);
    cyc(20);
    chk("R10 stretch ends", rst_out, 1'b0);
  endtask

  task automatic t_rst_idle(input bit x2);
    int short_len;
    int long_len;
    short_len = x2 ? 9 : 18;
    long_len  = x2 ? 20 : 35;
    x2_mode = x2;
    write_ctrl(2'b01);
    rst_pin_n = 1'b0;
    cyc(short_len);
    rst_pin_n = 1'b1;
    cyc(3);
    chk(x2 ? "R9 x2 short ignored" : "R9 x1 short ignored", rst_out, 1'b0);
    chk("R9 still idle", ctrl_q, 2'b01);
    rst_pin_n = 1'b0;
    cyc(long_len);
    chk(x2 ? "R9 x2 reset accepted" : "R9 x1 reset accepted", rst_out, 1'b1);
    rst_pin_n = 1'b1;
    cyc(30);
    chk("R11 idle cleared by reset", ctrl_q, 2'b00);
    chk("R10 reset done", rst_out, 1'b0);
    x2_mode = 1'b0;
  endtask

  task automatic t_rst_pd;
    wake_en = 2'b11;
    write_ctrl(2'b10);
    rst_pin_n = 1'b0;
    #1;
    chk("R11 reset pin runs osc", osc_en, 1'b1);
    cyc(80);
    chk("R11 reset in pd", rst_out, 1'b1);
    rst_pin_n = 1'b1;
    cyc(30);
    chk("R11 pd cleared by reset", ctrl_q, 2'b00);
  endtask

  initial begin
    apply_reset(1'b1);
    t_idle();
    t_pd_stab();
    t_pd_pins();
    t_rst_run();
    t_rst_idle(1'b0);
    t_rst_idle(1'b1);
    t_rst_pd();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule